// File: doc/BRIEF.md
# Endpoint Buffer Full Status Tracker

This block keeps the occupancy of the packet buffers behind a set of USB device endpoints and reports one buffer-full flag, for the endpoint chosen by an index register. Each endpoint is configured as IN (device to host) or OUT (host to device), and as single-buffered or double-buffered. A double-buffered endpoint has a fill pointer and a drain pointer. Each pointer toggles after every buffer it fills or drains, so the buffers empty in the order they were filled.

Software-side events apply to the indexed endpoint. These are a buffer-validate strobe for IN endpoints, a last-byte-read strobe from software or DMA for OUT endpoints, and a forced-clear strobe. USB-side events apply to the endpoint named on a separate endpoint-number input. These are the packet-sent-and-ACKed strobe for IN endpoints and the host-packet-ACKed strobe for OUT endpoints. A fill with no free buffer, or a drain with no full buffer, is dropped and raises a one-cycle error pulse.

Direction and double-buffer configuration are expected to stay static between resets.

Top module: `ep_buf_status`

## Requirements
- R1: On an IN endpoint, `sw_validate_i` fills a buffer and `usb_tx_ack_i` empties one. On a single-buffered IN endpoint, `buf_full_o` is 1 from the cycle after a validate until the cycle after the ACK.
- R2: On an OUT endpoint, `usb_rx_ack_i` fills a buffer and `rd_done_i` empties one. On a single-buffered OUT endpoint, `buf_full_o` follows these events with one cycle of latency.
- R3: For a double-buffered OUT endpoint, `buf_full_o` is 1 when at least one of its two buffers is full.
- R4: For a double-buffered IN endpoint, `buf_full_o` is 1 only when both of its buffers are full.
- R5: `clr_buf_i` on an indexed OUT endpoint empties the buffer at its drain pointer and then advances that pointer. It has no effect on an IN endpoint or on an OUT endpoint with no full buffer, and it never raises `err_o`.
- R6: A fill event with no free buffer, or a validate/ACK/read drain event with no full buffer, leaves the state unchanged. It sets `err_o` to 1 for exactly the following cycle.
- R7: After `rst_i` (master reset) or `bus_rst_i` (bus reset), every endpoint reads `buf_full_o`=0, `fill_ptr_o`=0 and `drain_ptr_o`=0.
- R8: On a double-buffered endpoint, `fill_ptr_o` and `drain_ptr_o` each toggle once per accepted fill or drain, starting at 0. A fill and a drain in the same cycle are both accepted when one buffer is full. On a single-buffered endpoint, both pointers stay 0.
- R9: Strobes for the other direction are ignored and raise no error. These are `sw_validate_i` or `usb_tx_ack_i` on an OUT endpoint, and `usb_rx_ack_i` or `rd_done_i` on an IN endpoint.
- R10: Software-side strobes act only on the endpoint `sel_ep_i`, and USB-side strobes act only on the endpoint `usb_ep_i`. Other endpoints keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Master reset, synchronous, active high |
| bus_rst_i | input | 1 | Bus reset, synchronous, active high |
| sel_ep_i | input | EPW | Index register: endpoint for the flag and for software strobes |
| usb_ep_i | input | EPW | Endpoint addressed by USB-side strobes |
| ep_is_in_i | input | NUM_EP | Per endpoint: 1 = IN, 0 = OUT |
| ep_dbl_i | input | NUM_EP | Per endpoint: 1 = double-buffered |
| sw_validate_i | input | 1 | Software validates an IN buffer |
| usb_tx_ack_i | input | 1 | IN packet sent and ACKed by host |
| usb_rx_ack_i | input | 1 | OUT packet received and ACKed |
| rd_done_i | input | 1 | Last byte of an OUT buffer read |
| clr_buf_i | input | 1 | Forced clear of an OUT buffer |
| buf_full_o | output | 1 | Buffer-full flag of the indexed endpoint |
| fill_ptr_o | output | 1 | Fill pointer of the indexed endpoint |
| drain_ptr_o | output | 1 | Drain pointer of the indexed endpoint |
| err_o | output | 1 | One-cycle pulse for a dropped fill or drain |

## Verification
The bench builds the block with NUM_EP=4 and assigns each endpoint a different configuration: OUT single, OUT double, IN single and IN double. This puts the OR and AND flag rules, pointer toggling and single-buffer pointer pinning side by side in one run. With two double-buffered endpoints, the forced clear can be tested with both buffers full, and a fill and a drain can be made to coincide on one endpoint. A USB-side strobe can be aimed at one endpoint while another is indexed.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;

    typedef struct packed {
        logic [1:0] full;
        logic       fill_ptr;
        logic       drain_ptr;
    } ep_state_t;

    typedef struct packed {
        logic fill;
        logic drain;
        logic clear;
    } ep_req_t;

    function automatic logic report_full(ep_state_t s, logic is_in, logic dbl);
        if (!dbl) return s.full[0];
        return is_in ? (&s.full) : (|s.full);
    endfunction

    function automatic logic next_ptr(logic p, logic dbl);
        return dbl ? ~p : 1'b0;
    endfunction

endpackage

// File: rtl/ep_event_decode.sv
module ep_event_decode
    import ep_buf_pkg::*;
#(
    parameter int EPW = 2,
    parameter int IDX = 0
) (
    input  logic [EPW-1:0] sel_ep_i,
    input  logic [EPW-1:0] usb_ep_i,
    input  logic           is_in_i,
    input  logic           sw_validate_i,
    input  logic           usb_tx_ack_i,
    input  logic           usb_rx_ack_i,
    input  logic           rd_done_i,
    input  logic           clr_buf_i,
    output ep_req_t        req_o
);
    localparam logic [EPW-1:0] MY_EP = IDX[EPW-1:0];

    logic sw_hit;
    logic usb_hit;

    always_comb begin
        sw_hit      = (sel_ep_i == MY_EP);
        usb_hit     = (usb_ep_i == MY_EP);
        req_o.fill  = is_in_i ? (sw_validate_i & sw_hit) : (usb_rx_ack_i & usb_hit);
        req_o.drain = is_in_i ? (usb_tx_ack_i & usb_hit) : (rd_done_i & sw_hit);
        req_o.clear = ~is_in_i & clr_buf_i & sw_hit;
    end
endmodule

// File: rtl/ep_buf_slot.sv
module ep_buf_slot
    import ep_buf_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      bus_rst_i,
    input  logic      dbl_i,
    input  ep_req_t   req_i,
    output ep_state_t state_o,
    output logic      err_o
);
    ep_state_t st_q;
    ep_state_t st_d;
    logic      can_fill;
    logic      can_drain;
    logic      do_fill;
    logic      do_drain;

    always_comb begin
        can_fill  = ~st_q.full[st_q.fill_ptr];
        can_drain = st_q.full[st_q.drain_ptr];
        do_fill   = req_i.fill & can_fill;
        do_drain  = (req_i.drain | req_i.clear) & can_drain;
        err_o     = (req_i.fill & ~can_fill) | (req_i.drain & ~can_drain);
        st_d      = st_q;
        if (do_drain) begin
            st_d.full[st_q.drain_ptr] = 1'b0;
            st_d.drain_ptr            = next_ptr(st_q.drain_ptr, dbl_i);
        end
        if (do_fill) begin
            st_d.full[st_q.fill_ptr] = 1'b1;
            st_d.fill_ptr            = next_ptr(st_q.fill_ptr, dbl_i);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || bus_rst_i) st_q <= '0;
        else                    st_q <= st_d;
    end

    assign state_o = st_q;
endmodule

// File: rtl/ep_buf_status.sv
module ep_buf_status
    import ep_buf_pkg::*;
#(
    parameter  int NUM_EP = 4,
    localparam int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_rst_i,
    input  logic [EPW-1:0]    sel_ep_i,
    input  logic [EPW-1:0]    usb_ep_i,
    input  logic [NUM_EP-1:0] ep_is_in_i,
    input  logic [NUM_EP-1:0] ep_dbl_i,
    input  logic              sw_validate_i,
    input  logic              usb_tx_ack_i,
    input  logic              usb_rx_ack_i,
    input  logic              rd_done_i,
    input  logic              clr_buf_i,
    output logic              buf_full_o,
    output logic              fill_ptr_o,
    output logic              drain_ptr_o,
    output logic              err_o
);
    ep_state_t         ep_st  [NUM_EP];
    ep_req_t           ep_req [NUM_EP];
    logic [NUM_EP-1:0] ep_err;
    logic              err_q;

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        ep_event_decode #(.EPW(EPW), .IDX(g)) u_dec (
            .sel_ep_i      (sel_ep_i),
            .usb_ep_i      (usb_ep_i),
            .is_in_i       (ep_is_in_i[g]),
            .sw_validate_i (sw_validate_i),
            .usb_tx_ack_i  (usb_tx_ack_i),
            .usb_rx_ack_i  (usb_rx_ack_i),
            .rd_done_i     (rd_done_i),
            .clr_buf_i     (clr_buf_i),
            .req_o         (ep_req[g])
        );
        ep_buf_slot u_slot (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .bus_rst_i (bus_rst_i),
            .dbl_i     (ep_dbl_i[g]),
            .req_i     (ep_req[g]),
            .state_o   (ep_st[g]),
            .err_o     (ep_err[g])
        );
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) err_q <= 1'b0;
        else       err_q <= (|ep_err) & ~bus_rst_i;
    end

    always_comb begin
        buf_full_o  = report_full(ep_st[sel_ep_i], ep_is_in_i[sel_ep_i], ep_dbl_i[sel_ep_i]);
        fill_ptr_o  = ep_st[sel_ep_i].fill_ptr;
        drain_ptr_o = ep_st[sel_ep_i].drain_ptr;
        err_o       = err_q;
    end
endmodule

// File: rtl/ep_buf_status_chk.sv
module ep_buf_status_chk #(
    parameter  int NUM_EP = 4,
    localparam int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              bus_rst_i,
    input logic [EPW-1:0]    sel_ep_i,
    input logic [EPW-1:0]    usb_ep_i,
    input logic [NUM_EP-1:0] ep_is_in_i,
    input logic              sw_validate_i,
    input logic              usb_tx_ack_i,
    input logic              rd_done_i,
    input logic              clr_buf_i,
    input logic              buf_full_o,
    input logic              fill_ptr_o,
    input logic              drain_ptr_o,
    input logic              err_o
);
    // R7: a bus reset leaves every endpoint empty with pointers at zero
    a_r7_bus_reset_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_rst_i |=> (!buf_full_o && !fill_ptr_o && !drain_ptr_o));

    // R6: validating an IN endpoint whose reported flag says no room gives an error
    a_r6_overfill_err: assert property (@(posedge clk_i) disable iff (rst_i)
        (sw_validate_i && ep_is_in_i[sel_ep_i] && buf_full_o && !bus_rst_i) |=> err_o);

    // R6: reading an OUT endpoint with no full buffer gives an error
    a_r6_underflow_err: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_done_i && !ep_is_in_i[sel_ep_i] && !buf_full_o && !bus_rst_i) |=> err_o);

    // R5: a forced clear does not touch an IN endpoint
    a_r5_clear_in_ignored: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_buf_i && ep_is_in_i[sel_ep_i] && !sw_validate_i && !bus_rst_i &&
         !(usb_tx_ack_i && usb_ep_i == sel_ep_i))
        |=> ((sel_ep_i != $past(sel_ep_i)) || (buf_full_o == $past(buf_full_o))));
endmodule

bind ep_buf_status ep_buf_status_chk #(.NUM_EP(NUM_EP)) u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .bus_rst_i     (bus_rst_i),
    .sel_ep_i      (sel_ep_i),
    .usb_ep_i      (usb_ep_i),
    .ep_is_in_i    (ep_is_in_i),
    .sw_validate_i (sw_validate_i),
    .usb_tx_ack_i  (usb_tx_ack_i),
    .rd_done_i     (rd_done_i),
    .clr_buf_i     (clr_buf_i),
    .buf_full_o    (buf_full_o),
    .fill_ptr_o    (fill_ptr_o),
    .drain_ptr_o   (drain_ptr_o),
    .err_o         (err_o)
);

// File: tb/ep_buf_status_tb_top.sv
module ep_buf_status_tb_top;
    localparam int NUM_EP = 4;
    localparam int EPW    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rst = 1'b0;
    logic [EPW-1:0] sel_ep = '0;
    logic [EPW-1:0] usb_ep = '0;
    // ep0 OUT single, ep1 OUT double, ep2 IN single, ep3 IN double
    logic [NUM_EP-1:0] is_in = 4'b1100;
    logic [NUM_EP-1:0] dbl   = 4'b1010;
    logic v = 0, ta = 0, ra = 0, rd = 0, cl = 0;
    logic full_o, fp_o, dp_o, err_o;

    always #2.5 clk = ~clk;

    ep_buf_status #(.NUM_EP(NUM_EP)) dut_i (
        .clk_i(clk), .rst_i(rst), .bus_rst_i(bus_rst),
        .sel_ep_i(sel_ep), .usb_ep_i(usb_ep),
        .ep_is_in_i(is_in), .ep_dbl_i(dbl),
        .sw_validate_i(v), .usb_tx_ack_i(ta), .usb_rx_ack_i(ra),
        .rd_done_i(rd), .clr_buf_i(cl),
        .buf_full_o(full_o), .fill_ptr_o(fp_o), .drain_ptr_o(dp_o), .err_o(err_o)
    );

    typedef struct packed { logic flag; logic err; logic fp; logic dp; } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit mfull [NUM_EP][2];
    bit mfp [NUM_EP];
    bit mdp [NUM_EP];

    task automatic op(input int s, input int u, input bit iv, input bit ita,
                      input bit ira, input bit ird, input bit icl, input bit ibr,
                      input string tag);
        exp_t e;
        bit eerr = 0;
        @(negedge clk);
        sel_ep = s[EPW-1:0]; usb_ep = u[EPW-1:0];
        v = iv; ta = ita; ra = ira; rd = ird; cl = icl; bus_rst = ibr;
        for (int k = 0; k < NUM_EP; k++) begin
            bit f, d, c, cf, cd, ofp, odp;
            if (ibr) begin
                mfull[k][0] = 0; mfull[k][1] = 0; mfp[k] = 0; mdp[k] = 0;
            end else begin
                f  = is_in[k] ? (iv && s == k) : (ira && u == k);
                d  = is_in[k] ? (ita && u == k) : (ird && s == k);
                c  = !is_in[k] && icl && s == k;
                ofp = mfp[k]; odp = mdp[k];
                cf = !mfull[k][ofp];
                cd = mfull[k][odp];
                if ((f && !cf) || (d && !cd)) eerr = 1;
                if ((d || c) && cd) begin
                    mfull[k][odp] = 0; mdp[k] = dbl[k] ? !odp : 1'b0;
                end
                if (f && cf) begin
                    mfull[k][ofp] = 1; mfp[k] = dbl[k] ? !ofp : 1'b0;
                end
            end
        end
        if (!dbl[s])    e.flag = mfull[s][0];
        else if (is_in[s]) e.flag = mfull[s][0] & mfull[s][1];
        else            e.flag = mfull[s][0] | mfull[s][1];
        e.err = eerr; e.fp = mfp[s]; e.dp = mdp[s];
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: sample one time unit after the edge that applied the op
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            exp_t a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{flag: full_o, err: err_o, fp: fp_o, dp: dp_o};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s: actual flag=%0b err=%0b fp=%0b dp=%0b expected flag=%0b err=%0b fp=%0b dp=%0b",
                         t, a.flag, a.err, a.fp, a.dp, e.flag, e.err, e.fp, e.dp);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        // R7 reset state on every endpoint
        for (int s = 0; s < NUM_EP; s++) op(s, 0, 0,0,0,0,0,0, "R7 reset");
        // R1 single IN (ep2)
        op(2, 0, 1,0,0,0,0,0, "R1 validate fills");
        op(2, 0, 1,0,0,0,0,0, "R6 overfill single IN");
        op(2, 2, 0,1,0,0,0,0, "R1 tx ack empties");
        op(2, 2, 0,1,0,0,0,0, "R6 underflow single IN");
        // R4/R8 double IN (ep3)
        op(3, 0, 1,0,0,0,0,0, "R4 one of two IN full");
        op(3, 0, 1,0,0,0,0,0, "R4 both IN full");
        op(3, 0, 1,0,0,0,0,0, "R6 overfill double IN");
        op(3, 3, 0,1,0,0,0,0, "R8 drain ptr toggles");
        op(3, 3, 0,1,0,0,0,0, "R8 drain ptr back");
        op(3, 3, 0,1,0,0,0,0, "R6 underflow double IN");
        // R2/R9 single OUT (ep0)
        op(0, 0, 1,0,0,0,0,0, "R9 validate on OUT ignored");
        op(0, 0, 0,0,1,0,0,0, "R2 rx ack fills");
        op(0, 0, 0,0,0,1,0,0, "R2 read empties");
        op(0, 0, 0,0,0,1,0,0, "R6 underflow single OUT");
        // R10 USB strobe aimed at ep1 while ep0 indexed
        op(0, 1, 0,0,1,0,0,0, "R10 other endpoint untouched");
        op(1, 0, 0,0,0,0,0,0, "R3 one OUT full reads 1");
        op(1, 1, 0,0,1,0,0,0, "R3 both OUT full");
        op(1, 1, 0,0,1,0,0,0, "R6 overfill double OUT");
        op(1, 0, 0,0,0,1,0,0, "R3 one left reads 1");
        op(1, 0, 0,0,0,1,0,0, "R3 both empty reads 0");
        // R5 forced clear on double OUT
        op(1, 1, 0,0,1,0,0,0, "R5 setup fill");
        op(1, 1, 0,0,1,0,0,0, "R5 setup fill");
        op(1, 0, 0,0,0,0,1,0, "R5 clear one advances ptr");
        op(1, 0, 0,0,0,0,1,0, "R5 clear second");
        op(1, 0, 0,0,0,0,1,0, "R5 clear on empty no error");
        // R5 clear on IN ignored
        op(2, 0, 1,0,0,0,0,0, "R5 setup IN");
        op(2, 0, 0,0,0,0,1,0, "R5 clear on IN ignored");
        op(2, 2, 0,1,0,0,0,0, "R1 drain after clear attempt");
        // R8 simultaneous fill and drain on double IN
        op(3, 0, 1,0,0,0,0,0, "R8 setup");
        op(3, 3, 1,1,0,0,0,0, "R8 fill and drain together");
        op(3, 1, 1,0,1,0,0,0, "R4 both full before bus reset");
        op(3, 0, 0,0,0,0,0,1, "R7 bus reset");
        for (int s = 0; s < NUM_EP; s++) op(s, 0, 0,0,0,0,0,0, "R7 after bus reset");
        // R9 wrong-direction USB strobes
        op(1, 1, 0,1,0,0,0,0, "R9 tx ack on OUT ignored");
        op(2, 2, 0,0,1,0,0,0, "R9 rx ack on IN ignored");
        op(2, 0, 0,0,0,1,0,0, "R9 read on IN ignored");
        op(0, 0, 0,0,0,0,0,0, "R10 idle");
        repeat (3) @(posedge clk);
        done = 1;
    end

    initial begin
        int n = 0;
        while (!done && n < 10000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule